// File: doc/BRIEF.md
# Masked Bus Watchpoint Comparator

This block is a single hardware watchpoint for a processor bus. It watches a 32-bit address, a 32-bit data word and eight bus-cycle qualifiers: transfer direction, transfer size, fetch versus data access, privilege level, an external condition, and cascade inputs from a neighbour. It compares each of them against a programmed value. Each compared bit has a matching mask bit. A mask bit of 1 makes that position a don't-care. A mask bit of 0 requires the observed bit to equal the value bit. When every field matches and the enable bit is set, the block raises a breakpoint request in the same cycle.

Two cascade outputs let a second instance qualify a first one. The range output is the raw full match, and it does not depend on enable. The chain output is a stored flag. In every cycle where the address and control fields match, the flag loads the data-field match result. It clears on reset and on every write to the control value register. In a two-instance arrangement, the second unit's chain and range outputs drive the first unit's chain and range inputs.

Six configuration registers are loaded through a simple write strobe with a register select and write data. A write takes effect at the clock edge where the strobe is sampled.

Top module: `bus_watchpoint`

## Requirements
- R1: Synchronous active-low reset clears all six registers and the chain flag. Directly after reset, bkpt_req and chain_out are 0. With all bus inputs at 0, range_out is 1.
- R2: The address field matches when `((bus_addr ^ addr_value) & ~addr_mask) == 0`. A mask bit of 1 ignores that address bit.
- R3: The data field matches when `((bus_data ^ data_value) & ~data_mask) == 0`, with the same don't-care rule as R2.
- R4: The observed control vector is bit0 bus_write (0 read, 1 write), bits 2:1 bus_size (00 byte, 01 half, 10 word, 11 reserved), bit3 bus_is_data (0 fetch, 1 data), bit4 bus_priv (0 user, 1 privileged), bit5 ext_cond, bit6 chain_in, bit7 range_in. It matches when each bit equals control value bits 7:0 or has its control mask bit set.
- R5: Control value bit 8 is the enable. It has no mask bit, and the control mask register holds only 8 bits. bkpt_req is 1 exactly when the address, data and control fields all match and enable is 1.
- R6: range_out is the full match of R2, R3 and R4, in the same cycle, regardless of enable.
- R7: At each clock edge without a control-value write, chain_out loads the data-field match if the address and control fields both match. Otherwise it holds its value.
- R8: A control-value write clears chain_out at that edge. The clear takes priority over a capture in the same cycle.
- R9: Register select codes are 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Writes with codes 6 and 7 change nothing.
- R10: A register write is visible in the comparison from the cycle after the strobe's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code (R9) |
| reg_wdata | input | 32 | Register write data |
| bus_addr | input | 32 | Observed bus address |
| bus_data | input | 32 | Observed bus data |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 2 | Transfer size code |
| bus_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_priv | input | 1 | 1 = privileged access |
| ext_cond | input | 1 | External qualifying condition |
| chain_in | input | 1 | Chain flag from neighbour watchpoint |
| range_in | input | 1 | Range match from neighbour watchpoint |
| bkpt_req | output | 1 | Breakpoint request |
| chain_out | output | 1 | Stored chain flag |
| range_out | output | 1 | Raw full match |

## Verification
Two events can land on the same clock edge: a capture into the chain flag, and a control-value write that clears it. The bench provokes this on purpose. In a long run of cycles, the address and data inputs toggle between matching and missing patterns. Every seventh cycle carries a control-value write of an unchanged value, so clears land on capturing, holding and idle cycles alike. After each edge, chain_out is compared against a reference flag in the bench. That flag applies the clear ahead of the capture.

// File: rtl/wp_pkg.sv
// Package: wp_pkg
// Shared constants and types for the bus watchpoint.
// Assumes: the control field has eight maskable bits plus an enable at bit 8.
package wp_pkg;

    localparam int CTRL_MASK_W = 8;
    localparam int CTRL_VAL_W  = CTRL_MASK_W + 1;
    localparam int NUM_REGS    = 6;
    localparam int SEL_W       = 3;

    // Bit positions of the control field
    localparam int CB_WRITE   = 0;
    localparam int CB_SIZE_LO = 1;
    localparam int CB_SIZE_HI = 2;
    localparam int CB_DATA    = 3;
    localparam int CB_PRIV    = 4;
    localparam int CB_EXT     = 5;
    localparam int CB_CHAIN   = 6;
    localparam int CB_RANGE   = 7;
    localparam int CB_ENABLE  = 8;

    // Register select codes
    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR_VAL = 3'd0,
        SEL_ADDR_MSK = 3'd1,
        SEL_DATA_VAL = 3'd2,
        SEL_DATA_MSK = 3'd3,
        SEL_CTRL_VAL = 3'd4,
        SEL_CTRL_MSK = 3'd5
    } wp_sel_e;

    // Observed control vector; packed MSB first so bit 0 is direction
    typedef struct packed {
        logic       range_in;
        logic       chain_in;
        logic       ext;
        logic       priv;
        logic       is_data;
        logic [1:0] size;
        logic       write;
    } wp_ctrl_obs_t;

endpackage

// File: rtl/wp_regfile.sv
// Module: wp_regfile
// Holds the six value/mask registers of one watchpoint and decodes the
// write strobe. It also flags a control-value write for the chain flag.
// Assumes: REG_W is at least ADDR_W, DATA_W and CTRL_VAL_W.
module wp_regfile
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       sel,
    input  logic [REG_W-1:0]       wdata,
    output logic [ADDR_W-1:0]      addr_val,
    output logic [ADDR_W-1:0]      addr_msk,
    output logic [DATA_W-1:0]      data_val,
    output logic [DATA_W-1:0]      data_msk,
    output logic [CTRL_VAL_W-1:0]  ctrl_val,
    output logic [CTRL_MASK_W-1:0] ctrl_msk,
    output logic                   ctrl_val_wr
);

    logic [NUM_REGS-1:0] hit;

    // Decode the select code into one write enable per register
    always_comb begin
        hit = '0;
        if (wr_en) begin
            case (sel)
                SEL_ADDR_VAL: hit[0] = 1'b1;
                SEL_ADDR_MSK: hit[1] = 1'b1;
                SEL_DATA_VAL: hit[2] = 1'b1;
                SEL_DATA_MSK: hit[3] = 1'b1;
                SEL_CTRL_VAL: hit[4] = 1'b1;
                SEL_CTRL_MSK: hit[5] = 1'b1;
                default:      hit    = '0;
            endcase
        end
    end

    assign ctrl_val_wr = hit[4];

    // Address value and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_val <= '0;
            addr_msk <= '0;
        end else begin
            if (hit[0]) addr_val <= wdata[ADDR_W-1:0];
            if (hit[1]) addr_msk <= wdata[ADDR_W-1:0];
        end
    end

    // Data value and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_val <= '0;
            data_msk <= '0;
        end else begin
            if (hit[2]) data_val <= wdata[DATA_W-1:0];
            if (hit[3]) data_msk <= wdata[DATA_W-1:0];
        end
    end

    // Control value (with enable) and control mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_val <= '0;
            ctrl_msk <= '0;
        end else begin
            if (hit[4]) ctrl_val <= wdata[CTRL_VAL_W-1:0];
            if (hit[5]) ctrl_msk <= wdata[CTRL_MASK_W-1:0];
        end
    end

endmodule

// File: rtl/wp_masked_cmp.sv
// Module: wp_masked_cmp
// Don't-care comparator. A bit matches when its mask is 1 or when the
// observed bit equals the value bit. The field matches when all bits do.
// Assumes: purely combinational, with no registered stage.
module wp_masked_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] obs,
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    output logic         match
);

    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit don't-care equality
        assign bit_ok[i] = msk[i] | ~(obs[i] ^ val[i]);
    end

    assign match = &bit_ok;

endmodule

// File: rtl/wp_chain_flag.sv
// Module: wp_chain_flag
// Stored chain flag. It loads din when cap_en is high. A clear request
// wins over a load in the same cycle.
// Assumes: clear and reset are both synchronous.
module wp_chain_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cap_en,
    input  logic din,
    output logic q
);

    // Clear has priority; otherwise capture when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (clr)    q <= 1'b0;
        else if (cap_en) q <= din;
    end

endmodule

// File: rtl/bus_watchpoint.sv
// Module: bus_watchpoint
// One hardware watchpoint. Masked address, data and control comparisons
// are combined into a full match. The full match drives range_out
// directly and bkpt_req through the enable. The chain flag loads the
// data match whenever the address and control fields match.
// Assumes: the bus inputs are stable around the clock edge, and writes
// arrive on a simple strobe interface.
module bus_watchpoint
    import wp_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int REG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic              bus_is_data,
    input  logic              bus_priv,
    input  logic              ext_cond,
    input  logic              chain_in,
    input  logic              range_in,
    output logic              bkpt_req,
    output logic              chain_out,
    output logic              range_out
);

    logic [ADDR_W-1:0]      addr_val_q, addr_msk_q;
    logic [DATA_W-1:0]      data_val_q, data_msk_q;
    logic [CTRL_VAL_W-1:0]  ctrl_val_q;
    logic [CTRL_MASK_W-1:0] ctrl_msk_q;
    logic                   ctrl_val_wr;
    wp_ctrl_obs_t           ctrl_obs;
    logic                   addr_match, data_match, ctrl_match;
    logic                   ac_match, full_match;

    wp_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .addr_val    (addr_val_q),
        .addr_msk    (addr_msk_q),
        .data_val    (data_val_q),
        .data_msk    (data_msk_q),
        .ctrl_val    (ctrl_val_q),
        .ctrl_msk    (ctrl_msk_q),
        .ctrl_val_wr (ctrl_val_wr)
    );

    // Gather the bus-cycle qualifiers into the control field layout
    always_comb begin
        ctrl_obs.write    = bus_write;
        ctrl_obs.size     = bus_size;
        ctrl_obs.is_data  = bus_is_data;
        ctrl_obs.priv     = bus_priv;
        ctrl_obs.ext      = ext_cond;
        ctrl_obs.chain_in = chain_in;
        ctrl_obs.range_in = range_in;
    end

    wp_masked_cmp #(.W(ADDR_W)) addr_cmp_i (
        .obs   (bus_addr),
        .val   (addr_val_q),
        .msk   (addr_msk_q),
        .match (addr_match)
    );

    wp_masked_cmp #(.W(DATA_W)) data_cmp_i (
        .obs   (bus_data),
        .val   (data_val_q),
        .msk   (data_msk_q),
        .match (data_match)
    );

    wp_masked_cmp #(.W(CTRL_MASK_W)) ctrl_cmp_i (
        .obs   (ctrl_obs),
        .val   (ctrl_val_q[CTRL_MASK_W-1:0]),
        .msk   (ctrl_msk_q),
        .match (ctrl_match)
    );

    // Combine field matches and apply the unmaskable enable
    always_comb begin
        ac_match   = addr_match & ctrl_match;
        full_match = ac_match & data_match;
        range_out  = full_match;
        bkpt_req   = full_match & ctrl_val_q[CB_ENABLE];
    end

    wp_chain_flag chain_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl_val_wr),
        .cap_en (ac_match),
        .din    (data_match),
        .q      (chain_out)
    );

endmodule

// File: rtl/wp_checker.sv
// Module: wp_checker
// Temporal checks on the bus watchpoint, attached through bind.
// Assumes: it sees the enable bit and the two partial matches inside the top.
module wp_checker
    import wp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [SEL_W-1:0] reg_sel,
    input logic             ctrl_en,
    input logic             ac_match,
    input logic             data_match,
    input logic             bkpt_req,
    input logic             range_out,
    input logic             chain_out
);

    logic cv_wr;
    assign cv_wr = reg_wr_en && (reg_sel == SEL_CTRL_VAL);

    AST_RESET_CLEARS_CHAIN: assert property (@(posedge clk)
        !rst_n |=> !chain_out);                                        // R1

    AST_BKPT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> ctrl_en);                                         // R5

    AST_BKPT_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> range_out);                                       // R6

    AST_CHAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cv_wr && ac_match) |=> (chain_out == $past(data_match)));    // R7

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cv_wr && !ac_match) |=> $stable(chain_out));                 // R7

    AST_CHAIN_CLEAR_ON_CTRL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr |=> !chain_out);                                         // R8

endmodule

bind bus_watchpoint wp_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .ctrl_en    (ctrl_val_q[8]),
    .ac_match   (ac_match),
    .data_match (data_match),
    .bkpt_req   (bkpt_req),
    .range_out  (range_out),
    .chain_out  (chain_out)
);

// File: tb/bus_watchpoint_tb_top.sv
module bus_watchpoint_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] bus_addr, bus_data;
    logic        bus_write;
    logic [1:0]  bus_size;
    logic        bus_is_data, bus_priv, ext_cond, chain_in, range_in;
    logic        bkpt_req, chain_out, range_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference registers and chain flag kept by the bench
    logic [31:0] s_av, s_am, s_dv, s_dm;
    logic [8:0]  s_cv;
    logic [7:0]  s_cm;
    logic        s_chain;

    always #(CLK_P/2) clk = ~clk;

    bus_watchpoint dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .bus_write   (bus_write),
        .bus_size    (bus_size),
        .bus_is_data (bus_is_data),
        .bus_priv    (bus_priv),
        .ext_cond    (ext_cond),
        .chain_in    (chain_in),
        .range_in    (range_in),
        .bkpt_req    (bkpt_req),
        .chain_out   (chain_out),
        .range_out   (range_out)
    );

    function automatic logic [7:0] obs_ctrl();
        return {range_in, chain_in, ext_cond, bus_priv, bus_is_data, bus_size, bus_write};
    endfunction

    function automatic logic exp_ac();
        return (((bus_addr ^ s_av) & ~s_am) == 32'd0) &&
               (((obs_ctrl() ^ s_cv[7:0]) & ~s_cm) == 8'd0);
    endfunction

    function automatic logic exp_dm();
        return ((bus_data ^ s_dv) & ~s_dm) == 32'd0;
    endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // One clock: check combinational outputs, advance the model, check the chain flag
    task automatic cycle(input string tag);
        logic ac, dm;
        #1;
        ac = exp_ac();
        dm = exp_dm();
        chk({tag, " R6 range_out"}, range_out, ac && dm);
        chk({tag, " R5 bkpt_req"},  bkpt_req,  ac && dm && s_cv[8]);
        @(posedge clk);
        if (!rst_n) begin
            s_av = '0; s_am = '0; s_dv = '0; s_dm = '0;
            s_cv = '0; s_cm = '0; s_chain = 1'b0;
        end else begin
            if (reg_wr_en && reg_sel == 3'd4) s_chain = 1'b0;
            else if (ac)                      s_chain = dm;
            if (reg_wr_en) begin
                case (reg_sel)
                    3'd0: s_av = reg_wdata;
                    3'd1: s_am = reg_wdata;
                    3'd2: s_dv = reg_wdata;
                    3'd3: s_dm = reg_wdata;
                    3'd4: s_cv = reg_wdata[8:0];
                    3'd5: s_cm = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        chk({tag, " R7/R8 chain_out"}, chain_out, s_chain);
        reg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = d;
        cycle("R10 write");
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        {range_in, chain_in, ext_cond, bus_priv, bus_is_data, bus_size, bus_write} = c;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = '0; reg_wdata = '0;
        bus_addr = '0; bus_data = '0; set_ctrl(8'h00);
        s_av = '0; s_am = '0; s_dv = '0; s_dm = '0; s_cv = '0; s_cm = '0; s_chain = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 bkpt_req after reset", bkpt_req, 1'b0);
        chk("R1 chain_out after reset", chain_out, 1'b0);
        chk("R1 range_out zero inputs", range_out, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: one-bit address sweep, unmasked then masked
        wr(3'd0, 32'hA5A5_3C3C);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_00FF);
        wr(3'd4, 32'h0000_0100);
        for (int i = 0; i < 32; i++) begin
            bus_addr = 32'hA5A5_3C3C ^ (32'd1 << i);
            cycle("R2 addr miss");
            wr(3'd1, 32'd1 << i);
            cycle("R2 addr masked");
            wr(3'd1, 32'd0);
        end
        bus_addr = 32'hA5A5_3C3C;
        cycle("R2 addr exact");

        // R3: one-bit data sweep
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h1234_8765);
        wr(3'd3, 32'd0);
        for (int i = 0; i < 32; i++) begin
            bus_data = 32'h1234_8765 ^ (32'd1 << i);
            cycle("R3 data miss");
            wr(3'd3, 32'd1 << i);
            cycle("R3 data masked");
            wr(3'd3, 32'd0);
        end
        bus_data = 32'h1234_8765;
        cycle("R3 data exact");

        // R4: every control combination under several mask patterns
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_01B6);
        for (int m = 0; m < 4; m++) begin
            wr(3'd5, (m == 0) ? 32'h00 : (m == 1) ? 32'h0F : (m == 2) ? 32'hF0 : 32'h5A);
            for (int c = 0; c < 256; c++) begin
                set_ctrl(c[7:0]);
                cycle("R4 ctrl sweep");
            end
        end

        // R5: enable clear, full match raises range only
        wr(3'd5, 32'h0000_0000);
        wr(3'd4, 32'h0000_00B6);
        for (int c = 0; c < 256; c++) begin
            set_ctrl(c[7:0]);
            cycle("R5 enable off");
        end
        // Mask write data bit 8 must not mask enable
        wr(3'd5, 32'h0000_01FF);
        set_ctrl(8'h00);
        #1;
        chk("R5 enable unmaskable bkpt_req", bkpt_req, 1'b0);
        chk("R5 enable unmaskable range_out", range_out, 1'b1);
        @(negedge clk);

        // R7/R8: chain capture with coincident control-value writes
        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h0000_CAFE);
        wr(3'd3, 32'h0000_0000);
        wr(3'd5, 32'h0000_00FF);
        wr(3'd4, 32'h0000_0100);
        for (int k = 0; k < 96; k++) begin
            bus_addr = (k % 3 != 2) ? 32'h0000_1000 : 32'h0000_2000;
            bus_data = ((k / 2) % 2 == 0) ? 32'h0000_CAFE : 32'h0000_BEEF;
            if (k % 7 == 3) begin
                reg_wr_en = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0000_0100;
            end
            cycle("R8 chain coincidence");
        end

        // R9: unused select codes change nothing
        bus_addr = 32'h0000_2000;
        bus_data = 32'h0000_CAFE;
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        #1;
        chk("R9 unused select range_out", range_out, 1'b0);
        chk("R9 unused select bkpt_req", bkpt_req, 1'b0);
        @(negedge clk);
        bus_addr = 32'h0000_1000;
        cycle("R9 still matches");

        // R1: reset mid-run clears registers and chain flag
        rst_n = 1'b0;
        cycle("R1 mid reset");
        rst_n = 1'b1;
        bus_addr = '0; bus_data = '0; set_ctrl(8'h00);
        cycle("R1 after mid reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule